// File: doc/BRIEF.md
# Receive-side software flow-control detector

This block sits between a UART receiver and its receive FIFO. Every character the receiver finishes arrives on a valid/ready stream. The block compares the character against four programmable codes: two resume (Xon) codes, A and B, and two pause (Xoff) codes, A and B. It drives a halt request to the local transmitter and keeps a flow-control interrupt flag. It also decides, character by character, whether the byte is forwarded to the FIFO or swallowed.

Matching works on a single code or on a two-character pair, as the mode field selects. An any-character resume option and a special-character detect option sit on top of the matching. The transmitter reports when it is in the middle of a character, so that a pause only takes effect at a character boundary. A read of the interrupt-identification register is signalled by a one-cycle strobe, which clears the flag.

Back-pressure works as follows. A byte is consumed on a clock edge where `rx_valid` and `rx_ready` are both high. A byte that is to be stored is offered on the store stream at the same time (`store_valid` high, `store_data` equal to `rx_data`). It is only consumed when the FIFO side is ready, so in that case `rx_ready` follows `store_ready`. A byte that is swallowed is always consumed at once, whatever `store_ready` is. While `rx_valid` is low, the block takes no flow-control action.

Top module: `fc_rx_detect`

## Requirements
- R1: With `rx_mode` = 00, no code is matched and every offered byte is stored. `tx_halt` is low in any cycle that follows a cycle with `rx_mode` = 00.
- R2: With `rx_mode` = 10, the codes Xon A and Xoff A are matched. With `rx_mode` = 01, the codes Xon B and Xoff B are matched. A consumed byte equal to the selected Xoff code sets the halt request and is not stored. If one byte equals both the Xoff and the Xon code, the Xoff match takes priority.
- R3: `tx_halt` follows the halt request only in cycles where `tx_busy` is low. While `tx_busy` is high, `tx_halt` keeps its value. The transmitter therefore stops only after the character it is sending has finished.
- R4: With `rx_mode` = 11, a pause needs Xoff A followed by Xoff B as consecutive consumed bytes, and a resume needs Xon A followed by Xon B. The first byte of a pair is stored. The completing second byte is not stored.
- R5: In pair mode, if the byte after a first code is not the matching second code, the partial match is dropped. That byte is stored as ordinary data, although it may itself start a new pair.
- R6: A matched Xon, single or completing a pair, clears the halt request and the interrupt flag, and is not stored.
- R7: An Xoff match sets the interrupt flag only when `irq_en` is high. `irq` is the flag ANDed with `irq_en`.
- R8: With `any_resume` high, any consumed byte that arrives while the halt request is set and is not an Xoff match clears the halt request and the flag. That byte is stored unless it equals an Xon code of the current mode (in pair mode, either Xon code).
- R9: With `special_en` high, a consumed byte equal to Xoff B that is not a flow-control match sets the flag (when `irq_en` is high). It does not change the halt request, and the byte is stored.
- R10: A high `iir_read` clears the flag. If a flag-setting byte is consumed in the same cycle, the set takes priority.
- R11: `store_valid` is high only for an offered byte that is to be stored. `rx_ready` is `store_ready` for such a byte and 1 for a swallowed byte. `store_data` equals `rx_data`.
- R12: After reset, `tx_halt`, `irq` and the internal pair-match state are all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Received byte accepted this cycle |
| rx_data | input | W | Received byte |
| store_valid | output | 1 | Byte offered to the receive FIFO |
| store_ready | input | 1 | FIFO can take a byte |
| store_data | output | W | Byte to the FIFO |
| rx_mode | input | 2 | 00 off, 10 code A, 01 code B, 11 pair A then B |
| any_resume | input | 1 | Any byte resumes a halted transmitter |
| special_en | input | 1 | Special-character (Xoff B) detect |
| irq_en | input | 1 | Flow-control interrupt enable |
| iir_read | input | 1 | Interrupt-identification read strobe |
| xon_a | input | W | Resume code A |
| xon_b | input | W | Resume code B |
| xoff_a | input | W | Pause code A |
| xoff_b | input | W | Pause code B |
| tx_busy | input | 1 | Transmitter is mid-character |
| tx_halt | output | 1 | Transmitter must stop at the next boundary |
| irq | output | 1 | Flow-control interrupt |

## Verification
Two pairs of events can land in the same cycle: a flag-setting byte (an Xoff match or a special byte) and an interrupt-identification read, and a pause decision and a busy transmitter. The directed part drives a special Xoff B byte in the very cycle `iir_read` is high and expects `irq` to stay high. It also raises a pause while `tx_busy` is high and expects `tx_halt` to move only once `tx_busy` falls. A random phase then mixes codes, stalls, reads and busy cycles so that these meet repeatedly, and every cycle is judged against a behavioural model.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_OFF  = 2'b00,
    FC_SEC  = 2'b01,
    FC_PRI  = 2'b10,
    FC_PAIR = 2'b11
  } fc_mode_e;

  typedef struct packed {
    logic is_off;     // pause match complete
    logic is_on;      // resume match complete
    logic xon_code;   // byte equals a resume code of the mode
    logic first_off;  // byte could open a pause pair
    logic first_on;   // byte could open a resume pair
    logic sp_hit;     // special-character detect
  } fc_class_t;
endpackage

// File: rtl/fc_classify.sv
module fc_classify
  import fc_pkg::*;
#(
  parameter int W = 8
) (
  input  fc_mode_e         mode,
  input  logic [W-1:0]     chr,
  input  logic [W-1:0]     xon_a,
  input  logic [W-1:0]     xon_b,
  input  logic [W-1:0]     xoff_a,
  input  logic [W-1:0]     xoff_b,
  input  logic             pend_off,
  input  logic             pend_on,
  input  logic             special_en,
  output fc_class_t        cls
);
  localparam int NCODE  = 4;
  localparam int I_ONA  = 0;
  localparam int I_ONB  = 1;
  localparam int I_OFFA = 2;
  localparam int I_OFFB = 3;

  logic [W-1:0]     codes [NCODE];
  logic [NCODE-1:0] eq;

  assign codes[I_ONA]  = xon_a;
  assign codes[I_ONB]  = xon_b;
  assign codes[I_OFFA] = xoff_a;
  assign codes[I_OFFB] = xoff_b;

  for (genvar i = 0; i < NCODE; i++) begin : g_cmp
    assign eq[i] = (chr == codes[i]);
  end

  always_comb begin
    cls = '0;
    unique case (mode)
      FC_PRI: begin
        cls.is_off   = eq[I_OFFA];
        cls.is_on    = !eq[I_OFFA] && eq[I_ONA];
        cls.xon_code = eq[I_ONA];
      end
      FC_SEC: begin
        cls.is_off   = eq[I_OFFB];
        cls.is_on    = !eq[I_OFFB] && eq[I_ONB];
        cls.xon_code = eq[I_ONB];
      end
      FC_PAIR: begin
        cls.is_off    = pend_off && eq[I_OFFB];
        cls.is_on     = !(pend_off && eq[I_OFFB]) && pend_on && eq[I_ONB];
        cls.xon_code  = eq[I_ONA] || eq[I_ONB];
        cls.first_off = eq[I_OFFA];
        cls.first_on  = eq[I_ONA];
      end
      default: ;
    endcase
    cls.sp_hit = special_en && eq[I_OFFB] && !cls.is_off && !cls.is_on;
  end
endmodule

// File: rtl/fc_pair_track.sv
module fc_pair_track (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pair,
  input  logic accept,
  input  logic done,
  input  logic first_off,
  input  logic first_on,
  output logic pend_off,
  output logic pend_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (!in_pair) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (accept) begin
      pend_off <= !done && first_off;
      pend_on  <= !done && first_on;
    end
  end
endmodule

// File: rtl/fc_flow_state.sv
module fc_flow_state (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_on,
  input  logic accept,
  input  logic is_off,
  input  logic is_on,
  input  logic wake,
  input  logic sp_hit,
  input  logic irq_en,
  input  logic iir_read,
  input  logic tx_busy,
  output logic halt_req,
  output logic flag,
  output logic tx_halt
);
  logic flag_set, flag_clr, resume;

  assign resume   = accept && (is_on || wake);
  assign flag_set = accept && (is_off || sp_hit) && irq_en;
  assign flag_clr = iir_read || resume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               halt_req <= 1'b0;
    else if (!flow_on)        halt_req <= 1'b0;
    else if (accept && is_off) halt_req <= 1'b1;
    else if (resume)          halt_req <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_halt <= 1'b0;
    else if (!flow_on) tx_halt <= 1'b0;
    else if (!tx_busy) tx_halt <= halt_req;
  end
endmodule

// File: rtl/fc_rx_detect.sv
module fc_rx_detect
  import fc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic [W-1:0] rx_data,
  output logic         store_valid,
  input  logic         store_ready,
  output logic [W-1:0] store_data,
  input  logic [1:0]   rx_mode,
  input  logic         any_resume,
  input  logic         special_en,
  input  logic         irq_en,
  input  logic         iir_read,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic         tx_busy,
  output logic         tx_halt,
  output logic         irq
);
  fc_mode_e  mode;
  fc_class_t cls;
  logic pend_off, pend_on, halt_req, flag;
  logic wake, keep, accept, done;

  assign mode = fc_mode_e'(rx_mode);

  fc_classify #(.W(W)) u_cls (
    .mode(mode), .chr(rx_data),
    .xon_a(xon_a), .xon_b(xon_b), .xoff_a(xoff_a), .xoff_b(xoff_b),
    .pend_off(pend_off), .pend_on(pend_on), .special_en(special_en),
    .cls(cls)
  );

  assign wake   = any_resume && halt_req && !cls.is_off && !cls.is_on;
  assign keep   = !cls.is_off && !cls.is_on && !(wake && cls.xon_code);
  assign rx_ready    = store_ready || !keep;
  assign accept      = rx_valid && rx_ready;
  assign store_valid = rx_valid && keep;
  assign store_data  = rx_data;
  assign done        = cls.is_off || cls.is_on || wake;

  fc_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .in_pair(mode == FC_PAIR), .accept(accept),
    .done(done), .first_off(cls.first_off), .first_on(cls.first_on),
    .pend_off(pend_off), .pend_on(pend_on)
  );

  fc_flow_state u_state (
    .clk(clk), .rst_n(rst_n), .flow_on(mode != FC_OFF), .accept(accept),
    .is_off(cls.is_off), .is_on(cls.is_on), .wake(wake), .sp_hit(cls.sp_hit),
    .irq_en(irq_en), .iir_read(iir_read), .tx_busy(tx_busy),
    .halt_req(halt_req), .flag(flag), .tx_halt(tx_halt)
  );

  assign irq = flag && irq_en;
endmodule

// File: rtl/fc_rx_detect_chk.sv
module fc_rx_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       store_valid,
  input logic       store_ready,
  input logic [1:0] rx_mode,
  input logic       irq_en,
  input logic       iir_read,
  input logic       tx_busy,
  input logic       tx_halt,
  input logic       irq
);
  p_off_no_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b00) |=> !tx_halt);
  p_off_stores_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_mode == 2'b00) |-> store_valid);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && rx_mode != 2'b00) |=> (tx_halt == $past(tx_halt)));
  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_read && !rx_valid) |=> !irq);
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    store_ready |-> rx_ready);
  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> rx_valid);
endmodule

bind fc_rx_detect fc_rx_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .store_valid(store_valid), .store_ready(store_ready), .rx_mode(rx_mode),
  .irq_en(irq_en), .iir_read(iir_read), .tx_busy(tx_busy),
  .tx_halt(tx_halt), .irq(irq)
);

// File: tb/sim_fc_rx_detect.sv
`timescale 1ns/1ps
module sim_fc_rx_detect;
  localparam logic [7:0] ONA = 8'h11, ONB = 8'h12, OFFA = 8'h13, OFFB = 8'h14;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, store_ready = 1, any_resume = 0, special_en = 0;
  logic irq_en = 0, iir_read = 0, tx_busy = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] rx_mode = 0;
  logic rx_ready, store_valid, tx_halt, irq;
  logic [7:0] store_data;

  int vectors = 0, errors = 0;
  bit finished = 0;

  // model state
  bit m_halt, m_flag, m_tx, m_poff, m_pon;

  always #10 clk = ~clk;

  fc_rx_detect #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .store_valid(store_valid), .store_ready(store_ready),
    .store_data(store_data), .rx_mode(rx_mode), .any_resume(any_resume),
    .special_en(special_en), .irq_en(irq_en), .iir_read(iir_read),
    .xon_a(ONA), .xon_b(ONB), .xoff_a(OFFA), .xoff_b(OFFB),
    .tx_busy(tx_busy), .tx_halt(tx_halt), .irq(irq)
  );

  // Behavioural evaluation of the current byte against the model state.
  task automatic evaluate(output bit off, output bit on, output bit wk,
                          output bit keep, output bit sp, output bit fo, output bit fn);
    bit xc;
    off = 0; on = 0; xc = 0; fo = 0; fn = 0;
    if (rx_mode == 2'b10) begin
      off = (rx_data == OFFA); on = !off && rx_data == ONA; xc = rx_data == ONA;
    end else if (rx_mode == 2'b01) begin
      off = (rx_data == OFFB); on = !off && rx_data == ONB; xc = rx_data == ONB;
    end else if (rx_mode == 2'b11) begin
      off = m_poff && rx_data == OFFB;
      on  = !off && m_pon && rx_data == ONB;
      xc  = rx_data == ONA || rx_data == ONB;
      fo  = rx_data == OFFA; fn = rx_data == ONA;
    end
    wk   = any_resume && m_halt && !off && !on;
    keep = !off && !on && !(wk && xc);
    sp   = special_en && rx_data == OFFB && !off && !on;
  endtask

  always @(posedge clk) begin
    bit off, on, wk, keep, sp, fo, fn, acc;
    if (!rst_n) begin
      m_halt = 0; m_flag = 0; m_tx = 0; m_poff = 0; m_pon = 0;
    end else begin
      evaluate(off, on, wk, keep, sp, fo, fn);
      acc = rx_valid && (store_ready || !keep);
      if (rx_mode == 0) m_tx = 0; else if (!tx_busy) m_tx = m_halt;
      if (acc && (off || sp) && irq_en) m_flag = 1;
      else if (iir_read || (acc && (on || wk))) m_flag = 0;
      if (rx_mode == 0) m_halt = 0;
      else if (acc && off) m_halt = 1;
      else if (acc && (on || wk)) m_halt = 0;
      if (rx_mode != 2'b11) begin m_poff = 0; m_pon = 0; end
      else if (acc) begin
        m_poff = !(off || on || wk) && fo;
        m_pon  = !(off || on || wk) && fn;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit off, on, wk, keep, sp, fo, fn;
    evaluate(off, on, wk, keep, sp, fo, fn);
    chk("R11", "store_valid", store_valid, rx_valid && keep);
    chk("R11", "rx_ready", rx_ready, store_ready || !keep);
    chk("R11", "store_data", store_data, rx_data);
    chk("R3", "tx_halt", tx_halt, m_tx);
    chk("R7", "irq", irq, m_flag && irq_en);
  endtask

  task automatic tick(input bit v, input logic [7:0] d);
    @(negedge clk);
    rx_valid = v; rx_data = d;
    #1 compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(0, 0);
    chk("R12", "reset tx_halt", tx_halt, 0);
    chk("R12", "reset irq", irq, 0);

    // R1 off mode
    tick(1, OFFA); chk("R1", "off stores", store_valid, 1);
    idle(3); chk("R1", "off no halt", tx_halt, 0);

    // R2 / R3 / R7 code A
    rx_mode = 2'b10; irq_en = 1; tx_busy = 1;
    tick(1, OFFA); chk("R2", "xoff A swallowed", store_valid, 0);
    idle(3); chk("R3", "held while busy", tx_halt, 0);
    chk("R7", "irq after xoff", irq, 1);
    tx_busy = 0; idle(2); chk("R3", "halt at boundary", tx_halt, 1);
    tick(1, ONA); chk("R6", "xon swallowed", store_valid, 0);
    idle(3); chk("R6", "resumed", tx_halt, 0); chk("R6", "flag cleared", irq, 0);

    // R2 code B
    rx_mode = 2'b01;
    tick(1, OFFA); chk("R2", "code A ignored in B mode", store_valid, 1);
    idle(3); chk("R2", "no halt from A", tx_halt, 0);
    tick(1, OFFB); idle(3); chk("R2", "xoff B halts", tx_halt, 1);
    tick(1, ONB); idle(3); chk("R6", "xon B resumes", tx_halt, 0);

    // R4 / R5 pair mode
    rx_mode = 2'b11;
    tick(1, OFFA); chk("R4", "first of pair stored", store_valid, 1);
    tick(1, OFFB); chk("R4", "second of pair swallowed", store_valid, 0);
    idle(3); chk("R4", "pair halts", tx_halt, 1);
    tick(1, ONA); tick(1, 8'h55); chk("R5", "break stored", store_valid, 1);
    tick(1, ONB); chk("R5", "orphan second stored", store_valid, 1);
    idle(3); chk("R5", "still halted", tx_halt, 1);
    tick(1, ONA); tick(1, ONB); chk("R4", "xon pair swallowed", store_valid, 0);
    idle(3); chk("R4", "pair resumes", tx_halt, 0);

    // R7 mask
    rx_mode = 2'b10; irq_en = 0;
    tick(1, OFFA); idle(2); chk("R7", "masked irq", irq, 0);
    irq_en = 1; idle(1); chk("R7", "flag not set when masked", irq, 0);
    tick(1, ONA); idle(3);

    // R8 any resume
    any_resume = 1;
    tick(1, OFFA); idle(3); chk("R8", "halted", tx_halt, 1);
    tick(1, 8'h55); chk("R8", "wake byte stored", store_valid, 1);
    idle(3); chk("R8", "woken", tx_halt, 0);
    tick(1, OFFA); idle(3);
    tick(1, ONA); chk("R8", "xon wake swallowed", store_valid, 0);
    idle(3); chk("R8", "woken by xon", tx_halt, 0);
    any_resume = 0;

    // R9 / R10 special character
    rx_mode = 2'b00; special_en = 1;
    tick(1, OFFB); chk("R9", "special stored", store_valid, 1);
    idle(1); chk("R9", "special irq", irq, 1); chk("R9", "special no halt", tx_halt, 0);
    iir_read = 1; idle(1); iir_read = 0; idle(1); chk("R10", "read clears", irq, 0);
    iir_read = 1; tick(1, OFFB); iir_read = 0;
    idle(1); chk("R10", "set beats read", irq, 1);
    iir_read = 1; idle(1); iir_read = 0; special_en = 0;

    // R11 back-pressure
    store_ready = 0;
    tick(1, 8'h55); chk("R11", "stall stored byte", rx_ready, 0);
    rx_mode = 2'b10;
    tick(1, OFFA); chk("R11", "swallow ignores stall", rx_ready, 1);
    idle(3); chk("R11", "swallowed xoff halts", tx_halt, 1);
    store_ready = 1; tick(1, ONA); idle(2);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if (n % 250 == 0) begin
        rx_mode = 2'($urandom_range(0, 3));
        any_resume = 1'($urandom_range(0, 1));
        special_en = 1'($urandom_range(0, 1));
      end
      irq_en      = ($urandom_range(0, 9) != 0);
      store_ready = ($urandom_range(0, 3) != 0);
      tx_busy     = ($urandom_range(0, 2) == 0);
      iir_read    = ($urandom_range(0, 7) == 0);
      begin
        logic [7:0] b;
        b = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 255))
                                         : 8'(8'h11 + $urandom_range(0, 3));
        tick(1'($urandom_range(0, 1)), b);
      end
    end
    iir_read = 0;
    idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule